// File: doc/BRIEF.md
# Two-Channel Indexed Register Bank with Split Down-Counter

This block is a byte-wide register file shared by two channels and reached only indirectly. Each channel exposes a pair of ports on a small byte bus: an index port that latches which internal register is addressed, and a data port that then reads or writes that register. Software first writes an index, then moves bytes through the data port. Each channel keeps its own index, so the two channels can be set up separately.

The bank holds a control byte whose bit 6 switches on a test mode, two read/write bytes that set up the divider of an external frequency synthesiser, a cable-status bit taken from a pin, and a 30-bit down-counter. Software uses the counter to measure the input clock: it lets the counter run for a known time and compares two readings. The counter is kept as two 15-bit halves, one per channel. Each half shows up in its own channel's bank as a pair of byte slices, and the slices are read live.

A two-state machine gates the counter. In HALT the counter holds. The START transition (control bit 6 seen set while in HALT) enters COUNT. In COUNT the counter drops by one on every clock. The STOP transition (bit 6 seen clear while in COUNT) returns to HALT. In every other case the state holds.

Top module: `idxbank_top`

## Requirements
- R1: The data port reaches the register chosen by the last byte written to that channel's index port. Each channel keeps its own index, and both indices reset to 0x00.
- R2: Channel 0 has its index port at address 0x1 and its data port at 0x3. Channel 1 has them at 0x9 and 0xB. Reads of any other address return 0x00, and writes to any other address change nothing.
- R3: Channel 0 index 0x01 is a read/write control byte that resets to 0x00. Its bit 6 is the test-mode enable.
- R4: The counter resets to 0x3FFFFFFF and holds its value while in HALT.
- R5: The state goes HALT to COUNT one clock after bit 6 is set, and COUNT to HALT one clock after it is cleared. The number of decrements therefore equals the number of clock edges during which the bit was set.
- R6: Index 0x20 reads counter bits 7:0 in channel 0 and bits 22:15 in channel 1. Index 0x21 reads bits 14:8 in channel 0 and bits 29:23 in channel 1, with bit 7 read as 0. A borrow passes from the low half into the high half.
- R7: Slice reads are live, not latched: two reads of a slice on consecutive cycles while counting differ by one. Writes to slice indices are ignored.
- R8: Channel 1 indices 0x02 and 0x03 are read/write bytes for the synthesiser feedback value and reference value. Both reset to 0x00 and drive the pll_f and pll_r outputs.
- R9: Index 0x0B in either channel reads the cable pin in bit 2 (1 means a 40-wire cable) and 0 in every other bit.
- R10: Data reads of indices that are not mapped in that channel return 0x00, and writes to them change nothing. bus_rdata is 0x00 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address; bit 3 selects the channel |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address and the register state |
| cable_40w | input | 1 | High when a 40-wire cable is fitted |
| pll_f | output | 8 | Synthesiser feedback setting |
| pll_r | output | 8 | Synthesiser reference setting |

## Verification
A slice read and a counter decrement can fall in the same cycle. The read then shows the value before the edge, and the next read shows the value after it. The bench provokes this by reading the low slice on two consecutive cycles right after START and expects 0xFF and then 0xFE. It also runs exactly 32768 decrements, which forces a borrow from the channel 0 half into the channel 1 half, and compares all four slices against a count kept in the bench.

// File: rtl/idxbank_pkg.sv
package idxbank_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int NUM_CH   = 2;
    localparam int CH_SEL_B = 3;

    localparam logic [2:0] OFF_INDEX = 3'd1;
    localparam logic [2:0] OFF_DATA  = 3'd3;

    localparam logic [7:0] IX_CTRL  = 8'h01;
    localparam logic [7:0] IX_FBDIV = 8'h02;
    localparam logic [7:0] IX_REFDV = 8'h03;
    localparam logic [7:0] IX_CABLE = 8'h0B;
    localparam logic [7:0] IX_SLLO  = 8'h20;
    localparam logic [7:0] IX_SLHI  = 8'h21;

    localparam int TST_BIT   = 6;
    localparam int CABLE_BIT = 2;

    typedef enum logic {
        RUN_HALT  = 1'b0,
        RUN_COUNT = 1'b1
    } run_state_t;

endpackage

// File: rtl/idxbank_port_dec.sv
module idxbank_port_dec
    import idxbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic              sel_ch,
    output logic [BYTE_W-1:0] sel_idx,
    output logic              data_wr,
    output logic              data_rd
);

    logic [2:0]        offset;
    logic              hit_index;
    logic              hit_data;
    logic [BYTE_W-1:0] idx_q [NUM_CH];

    always_comb begin
        sel_ch    = bus_addr[CH_SEL_B];
        offset    = bus_addr[2:0];
        hit_index = (offset == OFF_INDEX);
        hit_data  = (offset == OFF_DATA);
        data_wr   = bus_wr && hit_data;
        data_rd   = bus_rd && hit_data;
        sel_idx   = idx_q[sel_ch];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[c] <= '0;
            end else if (bus_wr && hit_index && (sel_ch == c[0])) begin
                idx_q[c] <= bus_wdata;
            end
        end
    end

endmodule

// File: rtl/idxbank_ctr.sv
module idxbank_ctr
    import idxbank_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tst_en,
    output logic                           running,
    output logic [NUM_CH-1:0][HALF_W-1:0]  halves
);

    run_state_t state_q;
    run_state_t state_d;
    logic [NUM_CH:0] borrow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALT:  if (tst_en)  state_d = RUN_COUNT;
            RUN_COUNT: if (!tst_en) state_d = RUN_HALT;
            default:   state_d = RUN_HALT;
        endcase
    end

    always_comb begin
        running   = (state_q == RUN_COUNT);
        borrow[0] = running;
    end

    for (genvar h = 0; h < NUM_CH; h++) begin : g_half
        always_comb begin
            borrow[h+1] = borrow[h] && (halves[h] == '0);
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                halves[h] <= '1;
            end else if (borrow[h]) begin
                halves[h] <= halves[h] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/idxbank_regs.sv
module idxbank_regs
    import idxbank_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_ch,
    input  logic [BYTE_W-1:0]             sel_idx,
    input  logic                          data_wr,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic [NUM_CH-1:0][HALF_W-1:0] halves,
    input  logic                          cable_40w,
    output logic [BYTE_W-1:0]             rd_val,
    output logic                          tst_en,
    output logic [BYTE_W-1:0]             pll_f,
    output logic [BYTE_W-1:0]             pll_r
);

    localparam int HI_W = HALF_W - BYTE_W;

    logic [BYTE_W-1:0] ctrl_q;
    logic [HALF_W-1:0] half_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pll_f  <= '0;
            pll_r  <= '0;
        end else if (data_wr) begin
            if (!sel_ch && sel_idx == IX_CTRL)  ctrl_q <= wdata;
            if (sel_ch && sel_idx == IX_FBDIV)  pll_f  <= wdata;
            if (sel_ch && sel_idx == IX_REFDV)  pll_r  <= wdata;
        end
    end

    always_comb begin
        tst_en   = ctrl_q[TST_BIT];
        half_sel = halves[sel_ch];
        rd_val   = '0;
        if (sel_idx == IX_SLLO) begin
            rd_val = half_sel[BYTE_W-1:0];
        end else if (sel_idx == IX_SLHI) begin
            rd_val = BYTE_W'(half_sel[HALF_W-1:BYTE_W]);
        end else if (sel_idx == IX_CABLE) begin
            rd_val[CABLE_BIT] = cable_40w;
        end else if (!sel_ch && sel_idx == IX_CTRL) begin
            rd_val = ctrl_q;
        end else if (sel_ch && sel_idx == IX_FBDIV) begin
            rd_val = pll_f;
        end else if (sel_ch && sel_idx == IX_REFDV) begin
            rd_val = pll_r;
        end
    end

    initial begin
        if (HI_W < 1 || HI_W > BYTE_W) $error("HALF_W out of range");
    end

endmodule

// File: rtl/idxbank_top.sv
module idxbank_top
    import idxbank_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cable_40w,
    output logic [BYTE_W-1:0] pll_f,
    output logic [BYTE_W-1:0] pll_r
);

    localparam int CNT_W = HALF_W * NUM_CH;

    logic                          sel_ch;
    logic [BYTE_W-1:0]             sel_idx;
    logic                          data_wr;
    logic                          data_rd;
    logic                          tst_en;
    logic                          running;
    logic [NUM_CH-1:0][HALF_W-1:0] halves;
    logic [BYTE_W-1:0]             rd_val;
    logic [CNT_W-1:0]              cnt_flat;

    idxbank_port_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .sel_ch    (sel_ch),
        .sel_idx   (sel_idx),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    idxbank_ctr #(.HALF_W(HALF_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tst_en  (tst_en),
        .running (running),
        .halves  (halves)
    );

    idxbank_regs #(.HALF_W(HALF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ch    (sel_ch),
        .sel_idx   (sel_idx),
        .data_wr   (data_wr),
        .wdata     (bus_wdata),
        .halves    (halves),
        .cable_40w (cable_40w),
        .rd_val    (rd_val),
        .tst_en    (tst_en),
        .pll_f     (pll_f),
        .pll_r     (pll_r)
    );

    always_comb begin
        cnt_flat  = halves;
        bus_rdata = data_rd ? rd_val : '0;
    end

endmodule

// File: rtl/idxbank_chk.sv
module idxbank_chk #(
    parameter int CNT_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tst_en,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_rdata,
    input logic [7:0]       pll_f,
    input logic [7:0]       pll_r
);

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(count));

    p_run_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (count == CNT_W'($past(count) - 1'b1)));

    p_stop_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tst_en |=> !running);

    p_start_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tst_en |=> running);

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

    p_pll_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pll_f) && $stable(pll_r)));

endmodule

bind idxbank_top idxbank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tst_en    (tst_en),
    .running   (running),
    .count     (cnt_flat),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .pll_f     (pll_f),
    .pll_r     (pll_r)
);

// File: tb/test_idxbank_top.sv
module test_idxbank_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cable_40w = 1'b0;
    logic [7:0] pll_f;
    logic [7:0] pll_r;

    int n_checks = 0;
    int n_errors = 0;
    logic [29:0] exp_cnt;

    localparam logic [3:0] A0_IX = 4'h1;
    localparam logic [3:0] A0_DT = 4'h3;
    localparam logic [3:0] A1_IX = 4'h9;
    localparam logic [3:0] A1_DT = 4'hB;

    always #10 clk = ~clk;

    idxbank_top i_idxbank_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cable_40w (cable_40w),
        .pll_f     (pll_f),
        .pll_r     (pll_r)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 30'h3FFF_FFFF;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic reg_read(input bit ch, input logic [7:0] ix, output logic [7:0] d);
        bus_write(ch ? A1_IX : A0_IX, ix);
        bus_read(ch ? A1_DT : A0_DT, d);
    endtask

    task automatic reg_write(input bit ch, input logic [7:0] ix, input logic [7:0] d);
        bus_write(ch ? A1_IX : A0_IX, ix);
        bus_write(ch ? A1_DT : A0_DT, d);
    endtask

    task automatic check_count(input string req);
        logic [7:0] v;
        reg_read(1'b0, 8'h20, v); check({req, " slice bits7:0"},   v, exp_cnt[7:0]);
        reg_read(1'b0, 8'h21, v); check({req, " slice bits14:8"},  v, {1'b0, exp_cnt[14:8]});
        reg_read(1'b1, 8'h20, v); check({req, " slice bits22:15"}, v, exp_cnt[22:15]);
        reg_read(1'b1, 8'h21, v); check({req, " slice bits29:23"}, v, {1'b0, exp_cnt[29:23]});
    endtask

    task automatic run_for(input int edges);
        bus_write(A0_IX, 8'h01);
        bus_write(A0_DT, 8'h40);
        repeat (edges - 1) @(posedge clk);
        bus_write(A0_DT, 8'h00);
        repeat (2) @(posedge clk);
        exp_cnt = exp_cnt - 30'(edges);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        do_reset();
        check("R8 pll_f reset", pll_f, 8'h00);
        check("R8 pll_r reset", pll_r, 8'h00);
        check("R10 rdata idle", bus_rdata, 8'h00);
        bus_read(A0_DT, v); check("R1 ch0 index resets to 0 (unmapped)", v, 8'h00);
        reg_read(1'b0, 8'h01, v); check("R3 ctrl reset", v, 8'h00);
        check_count("R4 reset count");
    endtask

    task automatic t_index_and_pll();
        logic [7:0] v;
        bus_write(A0_IX, 8'h21);
        bus_write(A1_IX, 8'h02);
        bus_write(A1_DT, 8'h5A);
        check("R8 pll_f write", pll_f, 8'h5A);
        bus_read(A0_DT, v); check("R1 ch0 index kept", v, 8'h7F);
        bus_read(A1_DT, v); check("R2 ch1 data port readback", v, 8'h5A);
        reg_write(1'b1, 8'h03, 8'hC3);
        check("R8 pll_r write", pll_r, 8'hC3);
        check("R8 pll_f unchanged", pll_f, 8'h5A);
        bus_write(4'hA, 8'h11);
        bus_write(4'h2, 8'h22);
        check("R2 other offsets ignored", {pll_f, pll_r}, 16'h5AC3);
        bus_read(A1_IX, v); check("R2 index port reads zero", v, 8'h00);
        reg_read(1'b0, 8'h02, v); check("R10 ch0 idx 02 unmapped", v, 8'h00);
    endtask

    task automatic t_ctrl_and_ignored();
        logic [7:0] v;
        reg_write(1'b0, 8'h01, 8'hA5);
        reg_read(1'b0, 8'h01, v); check("R3 ctrl readback", v, 8'hA5);
        reg_write(1'b1, 8'h01, 8'h40);
        reg_read(1'b1, 8'h01, v); check("R10 ch1 idx 01 unmapped", v, 8'h00);
        reg_write(1'b0, 8'h20, 8'h00);
        reg_write(1'b1, 8'h21, 8'h00);
        repeat (3) @(posedge clk);
        check_count("R7 slice writes ignored, R4 halted holds");
        reg_write(1'b0, 8'h01, 8'h00);
    endtask

    task automatic t_cable();
        logic [7:0] v;
        cable_40w = 1'b1;
        reg_read(1'b0, 8'h0B, v); check("R9 ch0 40-wire", v, 8'h04);
        reg_read(1'b1, 8'h0B, v); check("R9 ch1 40-wire", v, 8'h04);
        cable_40w = 1'b0;
        reg_read(1'b0, 8'h0B, v); check("R9 ch0 80-wire", v, 8'h00);
    endtask

    task automatic t_short_run();
        run_for(5);
        check_count("R5 five decrements");
        run_for(1);
        check_count("R5 single decrement");
    endtask

    task automatic t_borrow_run();
        do_reset();
        run_for(32768);
        check_count("R6 borrow into high half");
    endtask

    task automatic t_live_read();
        logic [7:0] v1;
        logic [7:0] v2;
        do_reset();
        bus_write(A0_IX, 8'h01);
        bus_write(A0_DT, 8'h40);
        bus_write(A0_IX, 8'h20);
        bus_read(A0_DT, v1);
        bus_read(A0_DT, v2);
        check("R7 live first read", v1, 8'hFF);
        check("R7 live next cycle", v2, 8'hFE);
        bus_write(A0_IX, 8'h01);
        bus_write(A0_DT, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_index_and_pll();
                t_ctrl_and_ignored();
                t_cable();
                t_short_run();
                t_borrow_run();
                t_live_read();
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule